// File: doc/BRIEF.md
# Vertical Field Timing Generator

This block derives the vertical-rate timing flags of a standard-definition video timing generator from a line-rate strobe. It keeps a line counter and a field bit. The counter steps once per line strobe and wraps at a programmed per-field line total. From the line number and the field, the block decodes a vertical blanking flag and a vertical sync flag. It also keeps two field-identity flags of opposite sense. The field sync flag is updated only on the first line of vertical sync. The digital field flag is updated only on the first line of vertical blanking.

Every position is a configuration input with separate values for field 1 and field 2: sync first and last line, blanking first and last line, and line total. An interlaced select chooses between two fields per frame and a single repeating field. A reference frame pulse, taken on a strobe, reloads the counter to a programmable line offset within field 1, so the outputs can be shifted against the reference. Each output has its own inversion bit. All four outputs are registered and change only on the clock edge that takes a strobe.

Top module: `vfield_gen`

## Requirements
- R1: While `rst` is high, and after it until the first strobe, the counter sits on line 1 of field 1 and every output equals its inversion bit, meaning its raw level is low.
- R2: After a strobe, the raw blanking flag is high exactly when the new line lies in the inclusive range from the blanking first line to the blanking last line of the new line's field.
- R3: After a strobe, the raw vertical sync flag is high exactly when the new line lies in the inclusive range from the sync first line to the sync last line of the new line's field.
- R4: In interlaced mode, the raw field sync flag takes 1 when the new line equals the sync first line of a field-1 line, and 0 when it equals the sync first line of a field-2 line. On every other line it holds its value.
- R5: In interlaced mode, the raw digital field flag takes 0 when the new line equals the blanking first line of a field-1 line, and 1 when it equals the blanking first line of a field-2 line. On every other line it holds its value.
- R6: In progressive mode (`interlaced` low), the raw field sync and digital field flags are low after every strobe, and each wrap returns to field 1.
- R7: A strobe without reference advances the line by one. When the current line is at or above the current field's total, it goes instead to line 1 of the other field (interlaced) or of field 1 (progressive).
- R8: A strobe with `frame_ref` high loads line `line_offset`+1 of field 1. `frame_ref` in a cycle without a strobe has no effect.
- R9: Each output is its raw level XOR its inversion bit: `pol_inv[0]` blanking, `[1]` field sync, `[2]` digital field, `[3]` vertical sync.
- R10: Outputs change only on the clock edge that samples `line_stb` high; between strobes they are stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| frame_ref | input | 1 | Reference frame pulse, taken only with line_stb |
| interlaced | input | 1 | 1 = two fields per frame, 0 = progressive |
| line_offset | input | LINE_W | Reload offset; reference loads line offset+1 |
| pol_inv | input | 4 | Per-output inversion bits |
| f1_total | input | LINE_W | Field 1 line total |
| f1_vs_first | input | LINE_W | Field 1 first sync line |
| f1_vs_last | input | LINE_W | Field 1 last sync line |
| f1_vb_first | input | LINE_W | Field 1 first blanking line |
| f1_vb_last | input | LINE_W | Field 1 last blanking line |
| f2_total | input | LINE_W | Field 2 line total |
| f2_vs_first | input | LINE_W | Field 2 first sync line |
| f2_vs_last | input | LINE_W | Field 2 last sync line |
| f2_vb_first | input | LINE_W | Field 2 first blanking line |
| f2_vb_last | input | LINE_W | Field 2 last blanking line |
| vblank_o | output | 1 | Vertical blanking flag |
| fsync_o | output | 1 | Field sync flag |
| fdig_o | output | 1 | Digital field flag |
| vsync_o | output | 1 | Vertical sync pulse |

## Verification
The bench places the sync first line on the last line of a field and the blanking window on line 1. A counter that wrapped one line late or early would miss those field flag updates, or take them in the wrong field. Reference pulses land mid-field and inside sync windows, where a design that treated the reload as a sync edge would flip the field sync flag wrongly. A reference pulse outside any strobe is applied, which a design that did not qualify it would act on. The bench switches between progressive and interlaced modes with random inversion masks, which catches field flags that leak through in progressive mode and outputs that change between strobes.

// File: rtl/vfg_pkg.sv
package vfg_pkg;

    localparam int unsigned NUM_FLAGS  = 4;
    localparam int unsigned IDX_VBLANK = 0;
    localparam int unsigned IDX_FSYNC  = 1;
    localparam int unsigned IDX_FDIG   = 2;
    localparam int unsigned IDX_VSYNC  = 3;

    typedef enum logic {
        FIELD_ONE = 1'b0,
        FIELD_TWO = 1'b1
    } field_e;

    // Packed so that member order matches the inversion-mask bit order.
    typedef struct packed {
        logic vsync;
        logic fdig;
        logic fsync;
        logic vblank;
    } flags_t;

    function automatic logic in_span(input int unsigned line,
                                     input int unsigned first,
                                     input int unsigned last);
        return (line >= first) && (line <= last);
    endfunction

endpackage

// File: rtl/vfg_line_counter.sv
module vfg_line_counter
    import vfg_pkg::*;
#(
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_stb,
    input  logic              frame_ref,
    input  logic              interlaced,
    input  logic [LINE_W-1:0] line_offset,
    input  logic [LINE_W-1:0] total_f1,
    input  logic [LINE_W-1:0] total_f2,
    output logic [LINE_W-1:0] nxt_line,
    output field_e            nxt_field
);

    logic [LINE_W-1:0] cur_line;
    field_e            cur_field;
    logic [LINE_W-1:0] cur_total;

    always_comb begin
        cur_total = (cur_field == FIELD_TWO) ? total_f2 : total_f1;
        if (frame_ref) begin
            nxt_line  = line_offset + LINE_W'(1);
            nxt_field = FIELD_ONE;
        end else if (cur_line >= cur_total) begin
            nxt_line  = LINE_W'(1);
            nxt_field = (interlaced && cur_field == FIELD_ONE) ? FIELD_TWO : FIELD_ONE;
        end else begin
            nxt_line  = cur_line + LINE_W'(1);
            nxt_field = cur_field;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_line  <= LINE_W'(1);
            cur_field <= FIELD_ONE;
        end else if (line_stb) begin
            cur_line  <= nxt_line;
            cur_field <= nxt_field;
        end
    end

    // R7: field only changes on a wrap
    assert_field_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !frame_ref && cur_line < cur_total) |=> $stable(cur_field));

    // R8: a reference on a strobe always lands in field 1
    assert_ref_field1_R8: assert property (@(posedge clk) disable iff (rst)
        (line_stb && frame_ref) |=> (cur_field == FIELD_ONE));

    // R10: no movement without a strobe
    assert_count_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !line_stb |=> ($stable(cur_line) && $stable(cur_field)));

endmodule

// File: rtl/vfg_field_flags.sv
module vfg_field_flags
    import vfg_pkg::*;
#(
    parameter int unsigned LINE_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_stb,
    input  logic                 interlaced,
    input  logic [NUM_FLAGS-1:0] pol_inv,
    input  logic [LINE_W-1:0]    nxt_line,
    input  field_e               nxt_field,
    input  logic [LINE_W-1:0]    vs_first [2],
    input  logic [LINE_W-1:0]    vs_last  [2],
    input  logic [LINE_W-1:0]    vb_first [2],
    input  logic [LINE_W-1:0]    vb_last  [2],
    output flags_t               flags_q
);

    logic   fs_q, fd_q;
    logic   fs_d, fd_d;
    flags_t raw_d;
    int unsigned fidx;

    always_comb begin
        fidx = (nxt_field == FIELD_TWO) ? 1 : 0;
        if (!interlaced) begin
            fs_d = 1'b0;
            fd_d = 1'b0;
        end else begin
            fs_d = (nxt_line == vs_first[fidx]) ? (nxt_field == FIELD_ONE) : fs_q;
            fd_d = (nxt_line == vb_first[fidx]) ? (nxt_field == FIELD_TWO) : fd_q;
        end
        raw_d.vblank = in_span(int'(nxt_line), int'(vb_first[fidx]), int'(vb_last[fidx]));
        raw_d.vsync  = in_span(int'(nxt_line), int'(vs_first[fidx]), int'(vs_last[fidx]));
        raw_d.fsync  = fs_d;
        raw_d.fdig   = fd_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q    <= 1'b0;
            fd_q    <= 1'b0;
            flags_q <= flags_t'(pol_inv);
        end else if (line_stb) begin
            fs_q    <= fs_d;
            fd_q    <= fd_d;
            flags_q <= flags_t'(raw_d) ^ flags_t'(pol_inv);
        end
    end

    // R6: progressive mode keeps both field flags low
    assert_prog_low_R6: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !interlaced) |=> (!fs_q && !fd_q));

    // R4: field sync moves only on the first sync line
    assert_fsync_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (line_stb && interlaced && nxt_line != vs_first[fidx]) |=> $stable(fs_q));

    // R5: digital field moves only on the first blanking line
    assert_fdig_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (line_stb && interlaced && nxt_line != vb_first[fidx]) |=> $stable(fd_q));

    // R10: outputs hold between strobes
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !line_stb |=> $stable(flags_q));

endmodule

// File: rtl/vfield_gen.sv
module vfield_gen
    import vfg_pkg::*;
#(
    parameter int unsigned LINE_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_stb,
    input  logic                 frame_ref,
    input  logic                 interlaced,
    input  logic [LINE_W-1:0]    line_offset,
    input  logic [NUM_FLAGS-1:0] pol_inv,
    input  logic [LINE_W-1:0]    f1_total,
    input  logic [LINE_W-1:0]    f1_vs_first,
    input  logic [LINE_W-1:0]    f1_vs_last,
    input  logic [LINE_W-1:0]    f1_vb_first,
    input  logic [LINE_W-1:0]    f1_vb_last,
    input  logic [LINE_W-1:0]    f2_total,
    input  logic [LINE_W-1:0]    f2_vs_first,
    input  logic [LINE_W-1:0]    f2_vs_last,
    input  logic [LINE_W-1:0]    f2_vb_first,
    input  logic [LINE_W-1:0]    f2_vb_last,
    output logic                 vblank_o,
    output logic                 fsync_o,
    output logic                 fdig_o,
    output logic                 vsync_o
);

    logic [LINE_W-1:0] nxt_line;
    field_e            nxt_field;
    flags_t            flags_q;

    logic [LINE_W-1:0] vs_first [2];
    logic [LINE_W-1:0] vs_last  [2];
    logic [LINE_W-1:0] vb_first [2];
    logic [LINE_W-1:0] vb_last  [2];

    assign vs_first[0] = f1_vs_first;
    assign vs_first[1] = f2_vs_first;
    assign vs_last[0]  = f1_vs_last;
    assign vs_last[1]  = f2_vs_last;
    assign vb_first[0] = f1_vb_first;
    assign vb_first[1] = f2_vb_first;
    assign vb_last[0]  = f1_vb_last;
    assign vb_last[1]  = f2_vb_last;

    vfg_line_counter #(.LINE_W(LINE_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .line_stb    (line_stb),
        .frame_ref   (frame_ref),
        .interlaced  (interlaced),
        .line_offset (line_offset),
        .total_f1    (f1_total),
        .total_f2    (f2_total),
        .nxt_line    (nxt_line),
        .nxt_field   (nxt_field)
    );

    vfg_field_flags #(.LINE_W(LINE_W)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .line_stb   (line_stb),
        .interlaced (interlaced),
        .pol_inv    (pol_inv),
        .nxt_line   (nxt_line),
        .nxt_field  (nxt_field),
        .vs_first   (vs_first),
        .vs_last    (vs_last),
        .vb_first   (vb_first),
        .vb_last    (vb_last),
        .flags_q    (flags_q)
    );

    assign vblank_o = flags_q.vblank;
    assign fsync_o  = flags_q.fsync;
    assign fdig_o   = flags_q.fdig;
    assign vsync_o  = flags_q.vsync;

endmodule

// File: tb/tb_vfield_gen.sv
module tb_vfield_gen;

    localparam int unsigned LW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_stb = 1'b0;
    logic frame_ref = 1'b0;
    logic interlaced = 1'b1;
    logic [LW-1:0] line_offset = '0;
    logic [3:0] pol_inv = 4'h0;
    logic [LW-1:0] c_tot [2];
    logic [LW-1:0] c_vsf [2];
    logic [LW-1:0] c_vsl [2];
    logic [LW-1:0] c_vbf [2];
    logic [LW-1:0] c_vbl [2];
    logic vblank_o, fsync_o, fdig_o, vsync_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    int m_ln, m_fld;
    bit m_fs, m_fd;
    logic [3:0] m_exp;

    always #10 clk = ~clk;

    vfield_gen #(.LINE_W(LW)) dut (
        .clk(clk), .rst(rst), .line_stb(line_stb), .frame_ref(frame_ref),
        .interlaced(interlaced), .line_offset(line_offset), .pol_inv(pol_inv),
        .f1_total(c_tot[0]), .f1_vs_first(c_vsf[0]), .f1_vs_last(c_vsl[0]),
        .f1_vb_first(c_vbf[0]), .f1_vb_last(c_vbl[0]),
        .f2_total(c_tot[1]), .f2_vs_first(c_vsf[1]), .f2_vs_last(c_vsl[1]),
        .f2_vb_first(c_vbf[1]), .f2_vb_last(c_vbl[1]),
        .vblank_o(vblank_o), .fsync_o(fsync_o), .fdig_o(fdig_o), .vsync_o(vsync_o)
    );

    function automatic logic [3:0] outs();
        return {vsync_o, fdig_o, fsync_o, vblank_o};
    endfunction

    function automatic bit span(int x, int a, int b);
        return (x >= a) && (x <= b);
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {vs,fd,fs,vb} got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_step(bit ref_in);
        int nl, nf;
        bit vb, vs;
        if (ref_in) begin
            nl = (int'(line_offset) + 1) % (1 << LW);
            nf = 0;
        end else if (m_ln >= int'(c_tot[m_fld])) begin
            nl = 1;
            nf = (interlaced && m_fld == 0) ? 1 : 0;
        end else begin
            nl = m_ln + 1;
            nf = m_fld;
        end
        if (!interlaced) begin
            m_fs = 1'b0;
            m_fd = 1'b0;
        end else begin
            if (nl == int'(c_vsf[nf])) m_fs = (nf == 0);
            if (nl == int'(c_vbf[nf])) m_fd = (nf == 1);
        end
        vb = span(nl, int'(c_vbf[nf]), int'(c_vbl[nf]));
        vs = span(nl, int'(c_vsf[nf]), int'(c_vsl[nf]));
        m_ln  = nl;
        m_fld = nf;
        m_exp = {vs, m_fd, m_fs, vb} ^ pol_inv;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        line_stb = 1'b0;
        frame_ref = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ln = 1; m_fld = 0; m_fs = 0; m_fd = 0;
        m_exp = pol_inv;
        @(negedge clk);
        chk("R1 reset state", outs(), m_exp);
    endtask

    // One line: strobe, check new outputs, optional stray reference, check hold.
    task automatic do_line(string tag, bit ref_in, bit stray);
        logic [3:0] first;
        @(negedge clk);
        line_stb  = 1'b1;
        frame_ref = ref_in;
        @(negedge clk);
        line_stb  = 1'b0;
        frame_ref = stray;
        model_step(ref_in);
        first = outs();
        chk(tag, first, m_exp);
        @(negedge clk);
        frame_ref = 1'b0;
        @(negedge clk);
        chk("R10 hold between strobes", outs(), first);
    endtask

    task automatic set_field(int f, int tot, int vsf, int vsl, int vbf, int vbl);
        c_tot[f] = LW'(tot); c_vsf[f] = LW'(vsf); c_vsl[f] = LW'(vsl);
        c_vbf[f] = LW'(vbf); c_vbl[f] = LW'(vbl);
    endtask

    task automatic rand_field(int f);
        int tot, a, b, c, d;
        tot = 4 + int'($urandom % 17);
        a = 1 + int'($urandom % tot);
        b = a + int'($urandom % (tot - a + 1));
        c = 1 + int'($urandom % tot);
        d = c + int'($urandom % (tot - c + 1));
        set_field(f, tot, a, b, c, d);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        set_field(0, 8, 2, 3, 1, 3);
        set_field(1, 9, 9, 9, 1, 2);
        interlaced = 1'b1;
        pol_inv = 4'h0;
        do_reset();

        // Directed: interlaced wrap, sync on last line of field 2, blanking on line 1
        for (int i = 0; i < 40; i++) do_line("R7/R4/R5 interlaced count", 1'b0, 1'b0);

        // Reference mid-field and inside a sync window
        line_offset = LW'(2);
        do_line("R8 reload to offset+1", 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) do_line("R8 after reload", 1'b0, 1'b0);
        line_offset = LW'(1);
        do_line("R8 reload onto first sync line", 1'b1, 1'b0);

        // Stray reference without a strobe is ignored
        for (int i = 0; i < 10; i++) do_line("R8 stray reference ignored", 1'b0, 1'b1);

        // All outputs inverted
        pol_inv = 4'hF;
        for (int i = 0; i < 20; i++) do_line("R9 inverted polarity", 1'b0, 1'b0);
        pol_inv = 4'h5;
        do_reset();
        for (int i = 0; i < 20; i++) do_line("R9 mixed polarity", 1'b0, 1'b0);

        // Progressive
        interlaced = 1'b0;
        pol_inv = 4'h0;
        for (int i = 0; i < 30; i++) do_line("R6 progressive", 1'b0, 1'b0);

        // Random configurations
        for (int k = 0; k < 60; k++) begin
            rand_field(0);
            rand_field(1);
            interlaced  = 1'($urandom % 4 != 0);
            pol_inv     = 4'($urandom);
            line_offset = LW'($urandom % c_tot[0]);
            if (k % 8 == 0) do_reset();
            do_line("R8 reload on new config", 1'b1, 1'b0);
            for (int i = 0; i < 50; i++) begin
                bit r, s;
                r = ($urandom % 29 == 0);
                s = ($urandom % 11 == 0);
                if (interlaced)
                    do_line("R2/R3/R4/R5/R9 random interlaced", r, s);
                else
                    do_line("R2/R3/R6/R9 random progressive", r, s);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule